// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Decoder with Self-Timed Chip Erase

This block models the command interface of a byte-wide parallel NOR flash. The host drives active-low chip, write and output enables, an address and a data byte; all of them are sampled on a system clock. Write cycles are checked against multi-step unlock sequences. These sequences select one of four things: array read, identification read, protection status read, or a full chip erase.

During a chip erase, an internal sequencer runs with no help from the host. It first programs every location of a small register-file array to 00h and verifies each one. It then erases every location to FFh and verifies each one. Throughout the erase, reads return a polling status byte instead of array data. The status byte has a completion bit, a bit that toggles on every read, and a timeout bit. A cycle budget limits the erase. When the budget runs out, the block locks into a failed state, and only a reset command clears it.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After `rst`, `dout` is 00h, and an array read at location i returns the power-up byte (29*i + 90) mod 256, where i is the low log2(DEPTH) address bits.
- R2: In read mode, each read returns the array byte at the addressed location. Reads never change the mode.
- R3: After the writes AAh@555h, 55h@2AAh, 90h@555h, a read with address bits [1:0]=00 returns C2h. Higher address bits are ignored.
- R4: In identification mode, address bits [1:0]=01 return 45h when `BOTTOM_BOOT`=0 and 46h when it is 1.
- R5: In identification mode, bits [1:0]=10 return 01h when `PROTECTED`=1 and 00h otherwise. Bits [1:0]=11 return 00h.
- R6: Outside an erase and outside the failed state, a write that does not continue a valid sequence returns the block to array read mode.
- R7: The erase starts only after the six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. The sixth write takes effect when the first of `we_n` or `ce_n` rises. While the erase runs, status bit 7 reads 0 and bit 5 reads 0.
- R8: While the erase is busy, status bit 6 inverts between consecutive reads. When the erase completes, the block returns to read mode, every location reads FFh, and bit 7 reads 1.
- R9: The erase writes 00h to every location, from lowest to highest, before it erases any location to FFh in the same order. An interrupted erase therefore leaves low locations at FFh and high locations at 00h.
- R10: When the erase uses `MAX_CYC` cycles, the status byte reads bit 5 = 1 and bit 7 = 0, and bit 6 keeps toggling. This state persists through every write except F0h. After F0h, array reads and new commands work again.
- R11: While the erase is busy, every write is ignored, including F0h.
- R12: Outside an erase, a write of F0h at any address, at any step of a sequence, returns the block to read mode and clears any partial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; low bits select the array location or the identification field |
| din | input | 8 | Write data (command byte) |
| dout | output | 8 | Registered read data: array byte, identification code or erase status; 00h when not reading |

## Verification
The hardest state to reach is an erase that stops partway through its erase-to-ones phase. Only such a stop shows from the ports that the pre-program pass happened, because a finished erase leaves nothing but FFh. The bench therefore builds a second instance with a short pacing count and a cycle budget that ends roughly halfway through the second phase. Both instances share the bus, so one command stream gives a full erase on one and a timeout on the other. After an F0h reset, the bench reads the timed-out array to find the FFh/00h split. The writes sent during the busy window are placed early enough that they reach the second instance before its timeout.

// File: rtl/fcmd_pkg.sv
`timescale 1ns/1ps
package fcmd_pkg;

  localparam int CMD_AW = 11;

  localparam logic [CMD_AW-1:0] ADR_KEY_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY_B = 11'h2AA;

  localparam logic [7:0] BYTE_KEY_A  = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B  = 8'h55;
  localparam logic [7:0] BYTE_IDENT  = 8'h90;
  localparam logic [7:0] BYTE_ARM    = 8'h80;
  localparam logic [7:0] BYTE_WIPE   = 8'h10;
  localparam logic [7:0] BYTE_ABORT  = 8'hF0;

  localparam logic [7:0] CODE_MAKER  = 8'hC2;
  localparam logic [7:0] CODE_TOP    = 8'h45;
  localparam logic [7:0] CODE_BOTTOM = 8'h46;

  typedef enum logic [1:0] {
    MD_READ,
    MD_IDENT,
    MD_ERASE,
    MD_FAIL
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_ARMED,
    SQ_AKEY1,
    SQ_AKEY2
  } seq_e;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_WRITE,
    EN_VERIFY
  } eng_e;

endpackage

// File: rtl/fcmd_bus_if.sv
`timescale 1ns/1ps
module fcmd_bus_if #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          wr_commit,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_act,
  output logic          rd_end
);

  logic wr_act;
  logic wr_q;
  logic rd_q;

  assign wr_act    = !ce_n && !we_n;
  assign rd_act    = !ce_n && !oe_n && we_n;
  // The write lands when the combined strobe releases: whichever pin rises first
  assign wr_commit = wr_q && !wr_act;
  assign rd_end    = rd_q && !rd_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end

  // a commit always follows a cycle in which the strobe was active
  p_commit_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(!ce_n && !we_n));

endmodule

// File: rtl/fcmd_decoder.sv
`timescale 1ns/1ps
module fcmd_decoder
  import fcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              eng_done,
  input  logic              eng_tmo,
  output mode_e             mode,
  output logic              start
);

  seq_e  seq_q;
  seq_e  seq_d;
  mode_e mode_d;
  logic  hit_a;
  logic  hit_b;

  assign hit_a = (cmd_addr == ADR_KEY_A);
  assign hit_b = (cmd_addr == ADR_KEY_B);

  always_comb begin
    seq_d  = seq_q;
    mode_d = mode;
    start  = 1'b0;
    if (mode == MD_ERASE) begin
      if (eng_tmo)       mode_d = MD_FAIL;
      else if (eng_done) mode_d = MD_READ;
    end else if (commit) begin
      if (cmd_data == BYTE_ABORT) begin
        seq_d  = SQ_IDLE;
        mode_d = MD_READ;
      end else if (mode != MD_FAIL) begin
        seq_d  = SQ_IDLE;
        mode_d = MD_READ;
        case (seq_q)
          SQ_IDLE: if (hit_a && cmd_data == BYTE_KEY_A) begin
            seq_d  = SQ_KEY1;
            mode_d = mode;
          end
          SQ_KEY1: if (hit_b && cmd_data == BYTE_KEY_B) begin
            seq_d  = SQ_KEY2;
            mode_d = mode;
          end
          SQ_KEY2: begin
            if (hit_a && cmd_data == BYTE_IDENT) begin
              mode_d = MD_IDENT;
            end else if (hit_a && cmd_data == BYTE_ARM) begin
              seq_d  = SQ_ARMED;
              mode_d = mode;
            end
          end
          SQ_ARMED: if (hit_a && cmd_data == BYTE_KEY_A) begin
            seq_d  = SQ_AKEY1;
            mode_d = mode;
          end
          SQ_AKEY1: if (hit_b && cmd_data == BYTE_KEY_B) begin
            seq_d  = SQ_AKEY2;
            mode_d = mode;
          end
          SQ_AKEY2: if (hit_a && cmd_data == BYTE_WIPE) begin
            mode_d = MD_ERASE;
            start  = 1'b1;
          end
          default: seq_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= SQ_IDLE;
      mode  <= MD_READ;
    end else begin
      seq_q <= seq_d;
      mode  <= mode_d;
    end
  end

  // failed state only leaves on an abort byte
  p_fail_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_FAIL && !(commit && cmd_data == BYTE_ABORT)) |=> mode == MD_FAIL);

  // an abort byte outside an erase always lands in read mode
  p_abort_read_r12: assert property (@(posedge clk) disable iff (rst)
    (mode != MD_ERASE && commit && cmd_data == BYTE_ABORT) |=> mode == MD_READ);

endmodule

// File: rtl/fcmd_array.sv
`timescale 1ns/1ps
module fcmd_array #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr_host,
  output logic [7:0]    rdata_host,
  input  logic [IW-1:0] raddr_eng,
  output logic [7:0]    rdata_eng
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 29 + 90);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_host = mem[raddr_host];
  assign rdata_eng  = mem[raddr_eng];

endmodule

// File: rtl/fcmd_erase_eng.sv
`timescale 1ns/1ps
module fcmd_erase_eng
  import fcmd_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int PACE    = 4,
  parameter int MAX_CYC = 4096,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(PACE + 1),
  localparam int TW = $clog2(MAX_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    rd_byte,
  output logic          we,
  output logic [IW-1:0] loc,
  output logic [7:0]    wdata,
  output logic          busy,
  output logic          done,
  output logic          tmo
);

  eng_e          st;
  logic          phase_era;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          last_loc;
  logic          ok;

  assign busy     = (st != EN_IDLE);
  assign last_loc = (loc == IW'(DEPTH - 1));
  assign wdata    = phase_era ? 8'hFF : 8'h00;
  assign ok       = (rd_byte == wdata);
  assign we       = (st == EN_WRITE) && (cnt == CW'(PACE - 1));
  assign tmo      = busy && (tcnt == TW'(MAX_CYC - 1));
  assign done     = (st == EN_VERIFY) && ok && last_loc && phase_era && !tmo;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= EN_IDLE;
      phase_era <= 1'b0;
      loc       <= '0;
      cnt       <= '0;
      tcnt      <= '0;
    end else if (st == EN_IDLE) begin
      if (start) begin
        st        <= EN_WRITE;
        phase_era <= 1'b0;
        loc       <= '0;
        cnt       <= '0;
        tcnt      <= '0;
      end
    end else if (tmo) begin
      st <= EN_IDLE;
    end else begin
      tcnt <= tcnt + 1'b1;
      case (st)
        EN_WRITE: begin
          if (cnt == CW'(PACE - 1)) begin
            cnt <= '0;
            st  <= EN_VERIFY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        EN_VERIFY: begin
          st <= EN_WRITE;
          if (ok) begin
            if (last_loc) begin
              loc <= '0;
              if (phase_era) st <= EN_IDLE;
              else           phase_era <= 1'b1;
            end else begin
              loc <= loc + 1'b1;
            end
          end
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  p_budget_bound_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> tcnt < TW'(MAX_CYC));

  p_end_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && tmo));

  // erase phase is entered only after the whole array verified at zero
  p_phase_order_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_era) |-> $past(st == EN_VERIFY && last_loc && rd_byte == 8'h00));

endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
  import fcmd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DEPTH       = 16,
  parameter int PACE        = 4,
  parameter int MAX_CYC     = 4096,
  parameter bit BOTTOM_BOOT = 1'b0,
  parameter bit PROTECTED   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout
);

  localparam int IW = $clog2(DEPTH);
  localparam logic [7:0] DEV_CODE  = BOTTOM_BOOT ? CODE_BOTTOM : CODE_TOP;
  localparam logic [7:0] PROT_CODE = PROTECTED ? 8'h01 : 8'h00;

  logic              wr_commit;
  logic [CMD_AW-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              rd_act;
  logic              rd_end;
  mode_e             mode;
  logic              start;
  logic              eng_we;
  logic [IW-1:0]     eng_loc;
  logic [7:0]        eng_wdata;
  logic [7:0]        eng_rbyte;
  logic              eng_busy;
  logic              eng_done;
  logic              eng_tmo;
  logic [7:0]        arr_byte;
  logic              tgl;
  logic [7:0]        rd_mux;

  fcmd_bus_if #(.AW(CMD_AW)) u_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr[CMD_AW-1:0]), .din(din),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_act(rd_act), .rd_end(rd_end)
  );

  fcmd_decoder u_dec (
    .clk(clk), .rst(rst), .commit(wr_commit), .cmd_addr(wr_addr),
    .cmd_data(wr_data), .eng_done(eng_done), .eng_tmo(eng_tmo),
    .mode(mode), .start(start)
  );

  fcmd_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst(rst), .we(eng_we), .waddr(eng_loc), .wdata(eng_wdata),
    .raddr_host(addr[IW-1:0]), .rdata_host(arr_byte),
    .raddr_eng(eng_loc), .rdata_eng(eng_rbyte)
  );

  fcmd_erase_eng #(.DEPTH(DEPTH), .PACE(PACE), .MAX_CYC(MAX_CYC)) u_eng (
    .clk(clk), .rst(rst), .start(start), .rd_byte(eng_rbyte),
    .we(eng_we), .loc(eng_loc), .wdata(eng_wdata),
    .busy(eng_busy), .done(eng_done), .tmo(eng_tmo)
  );

  always_comb begin
    case (mode)
      MD_READ:  rd_mux = arr_byte;
      MD_IDENT: begin
        case (addr[1:0])
          2'b00:   rd_mux = CODE_MAKER;
          2'b01:   rd_mux = DEV_CODE;
          2'b10:   rd_mux = PROT_CODE;
          default: rd_mux = 8'h00;
        endcase
      end
      MD_ERASE: rd_mux = {1'b0, tgl, 1'b0, 5'b0};
      default:  rd_mux = {1'b0, tgl, 1'b1, 5'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl  <= 1'b0;
      dout <= 8'h00;
    end else begin
      if (rd_end && (mode == MD_ERASE || mode == MD_FAIL)) tgl <= ~tgl;
      dout <= rd_act ? rd_mux : 8'h00;
    end
  end

  p_mode_tracks_engine_r11: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_ERASE) == eng_busy);

  p_busy_bit7_low_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_act && eng_busy) |=> !dout[7]);

  p_toggle_per_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_end && eng_busy) |=> tgl != $past(tgl));

endmodule

// File: tb/flash_cmd_fsm_tb.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb;

  localparam int AW    = 11;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic          ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dout_a, dout_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  flash_cmd_fsm #(.ADDR_W(AW), .DEPTH(DEPTH), .PACE(4), .MAX_CYC(4096),
                  .BOTTOM_BOOT(1'b0), .PROTECTED(1'b0)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout_a));

  flash_cmd_fsm #(.ADDR_W(AW), .DEPTH(DEPTH), .PACE(2), .MAX_CYC(72),
                  .BOTTOM_BOOT(1'b1), .PROTECTED(1'b1)) u_dut_to (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout_b));

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i % DEPTH) * 29 + 90);
  endfunction

  function automatic logic [7:0] id_byte(input logic [1:0] a, input bit bottom, input bit prot);
    case (a)
      2'b00:   return 8'hC2;
      2'b01:   return bottom ? 8'h46 : 8'h45;
      2'b10:   return prot ? 8'h01 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d, input bit ce_first = 1'b0);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] ra, output logic [7:0] rb);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    ra = dout_a; rb = dout_b;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic cmd_ident();
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'h90);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, rb, prev6;
    logic [AW-1:0] a;
    logic [7:0] d;
    bit got_done;
    int zero_cnt;

    void'($urandom(32'd2468));
    rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    repeat (4) @(negedge clk);
    check(dout_a, 8'h00, "R1 reset dout main");
    check(dout_b, 8'h00, "R1 reset dout second");
    rst = 1'b0;

    for (int i = 0; i < DEPTH; i++) begin
      bus_read(AW'(i), ra, rb);
      check(ra, init_byte(i), "R1 power-up byte main");
      check(rb, init_byte(i), "R1 power-up byte second");
    end

    for (int k = 0; k < 30; k++) begin
      a = AW'($urandom);
      bus_read(a, ra, rb);
      check(ra, init_byte(int'(a[3:0])), "R2 random array read");
    end

    cmd_ident();
    for (int k = 0; k < 4; k++) begin
      bus_read(AW'(k), ra, rb);
      check(ra, id_byte(2'(k), 1'b0, 1'b0), k == 0 ? "R3 maker code" : (k == 1 ? "R4 device code top" : "R5 protect field"));
      check(rb, id_byte(2'(k), 1'b1, 1'b1), k == 1 ? "R4 device code bottom" : "R5 protect/ident second");
    end
    for (int k = 0; k < 12; k++) begin
      a = AW'($urandom);
      bus_read(a, ra, rb);
      check(ra, id_byte(a[1:0], 1'b0, 1'b0), "R3 ident read with random high bits");
      check(rb, id_byte(a[1:0], 1'b1, 1'b1), "R5 ident read second instance");
    end

    bus_write(11'h000, 8'h12);
    bus_read(11'h000, ra, rb);
    check(ra, init_byte(0), "R6 stray write leaves ident mode");

    for (int k = 0; k < 8; k++) begin
      cmd_ident();
      do d = 8'($urandom); while (d == 8'hAA);
      bus_write(AW'($urandom), d);
      bus_read(11'h001, ra, rb);
      check(ra, init_byte(1), "R6 random out-of-sequence write");
    end

    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h123, 8'hF0);
    bus_write(11'h555, 8'h90);
    bus_read(11'h000, ra, rb);
    check(ra, init_byte(0), "R12 abort mid-sequence clears unlock");

    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'h80);
    bus_write(11'h555, 8'hAA);
    bus_write(11'h7FF, 8'hF0);
    bus_read(11'h002, ra, rb);
    check(ra, init_byte(2), "R12 abort after arm byte");

    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'h80);
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'h30);
    bus_read(11'h003, ra, rb);
    check(ra, init_byte(3), "R7 wrong final byte starts no erase");

    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'h80);
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'h10, 1'b1);
    bus_write(11'h000, 8'hF0);
    bus_write(11'h555, 8'hAA);
    bus_read(11'h000, ra, rb);
    check(ra & 8'hA0, 8'h00, "R11 abort ignored while busy, R7 bits 7 and 5 low");
    check(rb & 8'hA0, 8'h00, "R7 second instance busy status");
    prev6 = ra & 8'h40;

    got_done = 1'b0;
    for (int k = 0; k < 500; k++) begin
      bus_read(11'h000, ra, rb);
      if (ra[7]) begin
        got_done = 1'b1;
        break;
      end
      check(ra & 8'h40, prev6 ^ 8'h40, "R8 bit 6 toggles per read");
      check(ra & 8'h20, 8'h00, "R7 bit 5 low while busy");
      prev6 = ra & 8'h40;
    end
    check({7'd0, got_done}, 8'h01, "R8 erase completes");

    for (int i = 0; i < DEPTH; i++) begin
      bus_read(AW'(i), ra, rb);
      check(ra, 8'hFF, "R8 location erased");
    end
    bus_read(11'h005, ra, rb);
    check(ra, 8'hFF, "R8 stable after completion");

    bus_read(11'h000, ra, rb);
    check(rb & 8'hA0, 8'h20, "R10 timeout status");
    prev6 = rb & 8'h40;
    bus_read(11'h000, ra, rb);
    check(rb & 8'h40, prev6 ^ 8'h40, "R10 bit 6 toggles in failed state");

    bus_write(11'h555, 8'h10);
    bus_write(11'h555, 8'hAA);
    bus_read(11'h000, ra, rb);
    check(rb & 8'hA0, 8'h20, "R10 non-abort writes ignored");
    check(ra, 8'hFF, "R2 main stays readable");

    bus_write(11'h000, 8'hF0);
    zero_cnt = 0;
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(AW'(i), ra, rb);
      n_chk++;
      if (rb != 8'h00 && rb != 8'hFF) begin
        n_fail++;
        $display("FAIL R9 location %0d actual=%02h expected=00 or FF", i, rb);
      end
      if (rb == 8'h00) zero_cnt++;
    end
    bus_read(11'h000, ra, rb);
    check(rb, 8'hFF, "R9 lowest location erased first");
    bus_read(AW'(DEPTH - 1), ra, rb);
    check(rb, 8'h00, "R9 highest location still pre-programmed");
    check(8'(zero_cnt > 0 && zero_cnt < DEPTH), 8'h01, "R9 split between phases");

    cmd_ident();
    bus_read(11'h000, ra, rb);
    check(rb, 8'hC2, "R10 fresh command after abort");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule